// File: doc/BRIEF.md
# Scroll and VRAM Address Register Unit

This block keeps the address state of a tile-based video generator. It holds a 15-bit current video memory address, a 15-bit staging address, a 3-bit fine horizontal scroll and a single write-phase flag. The phase flag is shared by the scroll port and the address port. Host writes to the control, scroll and address ports update fields of the staging address. Accesses to the data port advance the current address by a step of 1 or 32. A status read returns the phase flag to its first phase.

While rendering runs, the unit follows the dot and line counters. It steps the tile column across the line. It steps the pixel row and the tile row at the end of the visible fetches. It reloads the horizontal part of the current address from the staging address once per line. On the pre-render line it also reloads the vertical part. The current address and the fine horizontal scroll leave the block for the fetch and pixel logic. Memory access itself happens outside the block.

Address fields, with v the current address: bits [4:0] are the tile column, [9:5] the tile row, [10] the horizontal table select, [11] the vertical table select and [14:12] the pixel row. The staging address uses the same layout.

Top module: `scroll_addr_unit`

## Requirements
- R1: After an asynchronous reset (rst_ni low), the current address, the staging address, the fine scroll, the write phase and the step select are all zero.
- R2: A control write sets staging bits [11:10] to wdata_i[1:0]. It sets the data-port step to 32 when wdata_i[2] is 1 and to 1 when it is 0.
- R3: A scroll write in phase 0 sets staging [4:0] to wdata_i[7:3] and fine_x_o to wdata_i[2:0]. A scroll write in phase 1 sets staging [14:12] to wdata_i[2:0] and staging [9:5] to wdata_i[7:3]. Every scroll write flips the phase. No other access changes fine_x_o.
- R4: An address write in phase 0 sets staging [13:8] to wdata_i[5:0] and clears staging [14]. An address write in phase 1 sets staging [7:0] to wdata_i and loads the whole updated staging value into vaddr_o on the same edge. Every address write flips the phase.
- R5: A status read forces the write phase to 0. A status read wins over a scroll or address write in the same cycle.
- R6: Each data-port access adds the selected step to vaddr_o, and the sum wraps to 15 bits.
- R7: On dots that are multiples of 8 from 8 to 248, and on dots 328 and 336, the tile column steps. From 31 it wraps to 0 and flips bit 10; otherwise it adds 1.
- R8: At dot 256 the pixel row [14:12] adds 1. When it overflows from 7, it wraps to 0 and the tile row advances. From 29 the tile row goes to 0 and bit 11 flips. From 31 it goes to 0 with no flip. Otherwise it adds 1.
- R9: At dot 257, vaddr_o bits under mask 0x041F take the staging value. On the pre-render line at dots 280 to 304, bits under mask 0x7BE0 take the staging value.
- R10: The events of R7 to R9 occur only when render_en_i is 1 and the line is visible (line_i below 240) or prerender_i is 1. Otherwise vaddr_o holds.
- R11: When events coincide, a phase-1 address write takes precedence over a data-port access, which takes precedence over the rendering events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_i | input | 9 | Dot counter within the line |
| line_i | input | 9 | Line counter |
| render_en_i | input | 1 | Background or sprite rendering enabled |
| prerender_i | input | 1 | Current line is the pre-render line |
| wdata_i | input | 8 | Host write data |
| ctrl_we_i | input | 1 | Control port write strobe |
| scroll_we_i | input | 1 | Scroll port write strobe |
| addr_we_i | input | 1 | Address port write strobe |
| data_acc_i | input | 1 | Data port access strobe (read or write) |
| status_rd_i | input | 1 | Status port read strobe |
| vaddr_o | output | 15 | Current video memory address |
| fine_x_o | output | 3 | Fine horizontal scroll |

## Verification
The staging fields are driven through scroll, control and address writes. They are then brought out through the dot-257 and pre-render copies, so that each field is shown to land at its own bit position. Tile-column steps are tried on fetch dots, on the two prefetch dots, and on non-event dots (264, 320). Row steps at dot 256 use rows 29, 31 and a plain row, which separates the table-flip, silent-wrap and add-one cases. Data-port steps of 1 and 32 are run, including a wrap past 0x7FFF. Runs with rendering off, on a blanking line and on a visible line that is not the pre-render line confirm that vaddr_o does not change. A data access on a fetch dot shows that the host access wins.

// File: rtl/scroll_addr_pkg.sv
package scroll_addr_pkg;
  localparam int unsigned VADDR_W = 15;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FX_W    = 3;

  typedef logic [VADDR_W-1:0] vaddr_t;

  // field masks
  localparam vaddr_t HORIZ_MASK = 15'h041F;
  localparam vaddr_t VERT_MASK  = 15'h7BE0;

  // event dots
  localparam int unsigned DOT_X_FIRST  = 8;
  localparam int unsigned DOT_Y_STEP   = 256;
  localparam int unsigned DOT_H_COPY   = 257;
  localparam int unsigned DOT_PRE_X0   = 328;
  localparam int unsigned DOT_PRE_X1   = 336;
  localparam int unsigned DOT_V_FIRST  = 280;
  localparam int unsigned DOT_V_LAST   = 304;

  localparam logic [4:0] ROW_LAST_VIS = 5'd29;
  localparam logic [4:0] ROW_MAX      = 5'd31;

  function automatic vaddr_t f_step_x(vaddr_t v);
    vaddr_t r;
    r = v;
    if (&v[4:0]) begin
      r[4:0] = '0;
      r[10]  = ~v[10];
    end else begin
      r[4:0] = v[4:0] + 5'd1;
    end
    return r;
  endfunction

  function automatic vaddr_t f_step_y(vaddr_t v);
    vaddr_t r;
    r = v;
    if (!(&v[14:12])) begin
      r[14:12] = v[14:12] + 3'd1;
    end else begin
      r[14:12] = '0;
      if (v[9:5] == ROW_LAST_VIS) begin
        r[9:5] = '0;
        r[11]  = ~v[11];
      end else if (v[9:5] == ROW_MAX) begin
        r[9:5] = '0;
      end else begin
        r[9:5] = v[9:5] + 5'd1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/scroll_render_ctl.sv
module scroll_render_ctl
  import scroll_addr_pkg::*;
#(
  parameter int unsigned DOT_W     = 9,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned VIS_LINES = 240
) (
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_en_i,
  input  logic              prerender_i,
  output logic              ev_step_x_o,
  output logic              ev_step_y_o,
  output logic              ev_copy_h_o,
  output logic              ev_copy_v_o
);
  localparam logic [DOT_W-1:0]  D_X_FIRST = DOT_W'(DOT_X_FIRST);
  localparam logic [DOT_W-1:0]  D_Y_STEP  = DOT_W'(DOT_Y_STEP);
  localparam logic [DOT_W-1:0]  D_H_COPY  = DOT_W'(DOT_H_COPY);
  localparam logic [DOT_W-1:0]  D_PRE_X0  = DOT_W'(DOT_PRE_X0);
  localparam logic [DOT_W-1:0]  D_PRE_X1  = DOT_W'(DOT_PRE_X1);
  localparam logic [DOT_W-1:0]  D_V_FIRST = DOT_W'(DOT_V_FIRST);
  localparam logic [DOT_W-1:0]  D_V_LAST  = DOT_W'(DOT_V_LAST);
  localparam logic [LINE_W-1:0] L_VIS     = LINE_W'(VIS_LINES);

  logic active;
  logic tile_dot;
  logic in_fetch;
  logic in_prefetch;

  assign active      = render_en_i && ((line_i < L_VIS) || prerender_i);
  assign tile_dot    = (dot_i[2:0] == 3'd0);
  assign in_fetch    = (dot_i >= D_X_FIRST) && (dot_i < D_Y_STEP);
  assign in_prefetch = (dot_i == D_PRE_X0) || (dot_i == D_PRE_X1);

  assign ev_step_x_o = active && tile_dot && (in_fetch || in_prefetch);
  assign ev_step_y_o = active && (dot_i == D_Y_STEP);
  assign ev_copy_h_o = active && (dot_i == D_H_COPY);
  assign ev_copy_v_o = active && prerender_i &&
                       (dot_i >= D_V_FIRST) && (dot_i <= D_V_LAST);
endmodule

// File: rtl/scroll_tmp_reg.sv
module scroll_tmp_reg
  import scroll_addr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ctrl_we_i,
  input  logic              scroll_we_i,
  input  logic              addr_we_i,
  input  logic              status_rd_i,
  output vaddr_t            tmp_o,
  output vaddr_t            load_val_o,
  output logic              load_v_o,
  output logic [FX_W-1:0]   fine_x_o,
  output logic              toggle_o,
  output logic              step_wide_o
);
  vaddr_t          tmp_q, tmp_d;
  logic [FX_W-1:0] fx_q, fx_d;
  logic            tog_q, tog_d;
  logic            wide_q, wide_d;

  always_comb begin
    tmp_d  = tmp_q;
    fx_d   = fx_q;
    tog_d  = tog_q;
    wide_d = wide_q;
    if (ctrl_we_i) begin
      tmp_d[11:10] = wdata_i[1:0];
      wide_d       = wdata_i[2];
    end
    if (scroll_we_i) begin
      if (!tog_q) begin
        tmp_d[4:0] = wdata_i[7:3];
        fx_d       = wdata_i[2:0];
      end else begin
        tmp_d[14:12] = wdata_i[2:0];
        tmp_d[9:5]   = wdata_i[7:3];
      end
      tog_d = ~tog_q;
    end
    if (addr_we_i) begin
      if (!tog_q) begin
        tmp_d[13:8] = wdata_i[5:0];
        tmp_d[14]   = 1'b0;
      end else begin
        tmp_d[7:0] = wdata_i;
      end
      tog_d = ~tog_q;
    end
    if (status_rd_i) tog_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmp_q  <= '0;
      fx_q   <= '0;
      tog_q  <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      tmp_q  <= tmp_d;
      fx_q   <= fx_d;
      tog_q  <= tog_d;
      wide_q <= wide_d;
    end
  end

  assign tmp_o       = tmp_q;
  assign load_val_o  = {tmp_q[14:8], wdata_i};
  assign load_v_o    = addr_we_i && tog_q;
  assign fine_x_o    = fx_q;
  assign toggle_o    = tog_q;
  assign step_wide_o = wide_q;
endmodule

// File: rtl/scroll_cur_reg.sv
module scroll_cur_reg
  import scroll_addr_pkg::*;
#(
  parameter int unsigned STEP_NARROW = 1,
  parameter int unsigned STEP_WIDE   = 32
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  vaddr_t tmp_i,
  input  vaddr_t load_val_i,
  input  logic   load_v_i,
  input  logic   data_acc_i,
  input  logic   step_wide_i,
  input  logic   ev_step_x_i,
  input  logic   ev_step_y_i,
  input  logic   ev_copy_h_i,
  input  logic   ev_copy_v_i,
  output vaddr_t vaddr_o
);
  localparam vaddr_t INC_N = VADDR_W'(STEP_NARROW);
  localparam vaddr_t INC_W = VADDR_W'(STEP_WIDE);

  vaddr_t v_q, v_d;

  always_comb begin
    v_d = v_q;
    if (load_v_i) begin
      v_d = load_val_i;
    end else if (data_acc_i) begin
      v_d = v_q + (step_wide_i ? INC_W : INC_N);
    end else begin
      if (ev_step_x_i) v_d = f_step_x(v_q);
      if (ev_step_y_i) v_d = f_step_y(v_q);
      if (ev_copy_h_i) v_d = (v_q & ~HORIZ_MASK) | (tmp_i & HORIZ_MASK);
      if (ev_copy_v_i) v_d = (v_q & ~VERT_MASK) | (tmp_i & VERT_MASK);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= v_d;
  end

  assign vaddr_o = v_q;
endmodule

// File: rtl/scroll_addr_unit.sv
module scroll_addr_unit
  import scroll_addr_pkg::*;
#(
  parameter int unsigned DOT_W     = 9,
  parameter int unsigned LINE_W    = 9,
  parameter int unsigned VIS_LINES = 240
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              render_en_i,
  input  logic              prerender_i,
  input  logic [7:0]        wdata_i,
  input  logic              ctrl_we_i,
  input  logic              scroll_we_i,
  input  logic              addr_we_i,
  input  logic              data_acc_i,
  input  logic              status_rd_i,
  output logic [14:0]       vaddr_o,
  output logic [2:0]        fine_x_o
);
  vaddr_t tmp, load_val;
  logic   load_v, wr_toggle, step_wide;
  logic   ev_x, ev_y, ev_h, ev_v;

  scroll_render_ctl #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES)
  ) u_ctl (
    .dot_i       (dot_i),
    .line_i      (line_i),
    .render_en_i (render_en_i),
    .prerender_i (prerender_i),
    .ev_step_x_o (ev_x),
    .ev_step_y_o (ev_y),
    .ev_copy_h_o (ev_h),
    .ev_copy_v_o (ev_v)
  );

  scroll_tmp_reg u_tmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wdata_i     (wdata_i),
    .ctrl_we_i   (ctrl_we_i),
    .scroll_we_i (scroll_we_i),
    .addr_we_i   (addr_we_i),
    .status_rd_i (status_rd_i),
    .tmp_o       (tmp),
    .load_val_o  (load_val),
    .load_v_o    (load_v),
    .fine_x_o    (fine_x_o),
    .toggle_o    (wr_toggle),
    .step_wide_o (step_wide)
  );

  scroll_cur_reg u_cur (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tmp_i       (tmp),
    .load_val_i  (load_val),
    .load_v_i    (load_v),
    .data_acc_i  (data_acc_i),
    .step_wide_i (step_wide),
    .ev_step_x_i (ev_x),
    .ev_step_y_i (ev_y),
    .ev_copy_h_i (ev_h),
    .ev_copy_v_i (ev_v),
    .vaddr_o     (vaddr_o)
  );
endmodule

// File: rtl/scroll_addr_chk.sv
module scroll_addr_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        render_en_i,
  input logic [7:0]  wdata_i,
  input logic        ctrl_we_i,
  input logic        scroll_we_i,
  input logic        addr_we_i,
  input logic        data_acc_i,
  input logic        status_rd_i,
  input logic [14:0] vaddr_o,
  input logic [2:0]  fine_x_o,
  input logic        toggle_i,
  input logic        step_wide_i
);
  AST_FX_ONLY_SCROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scroll_we_i |=> $stable(fine_x_o)); // R3

  AST_STATUS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i |=> !toggle_i); // R5

  AST_PHASE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((scroll_we_i || addr_we_i) && !status_rd_i) |=> (toggle_i != $past(toggle_i))); // R3

  AST_LOAD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_we_i && toggle_i) |=> (vaddr_o[7:0] == $past(wdata_i))); // R4

  AST_DATA_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && !(addr_we_i && toggle_i)) |=>
      (vaddr_o == 15'($past(vaddr_o) + ($past(step_wide_i) ? 15'd32 : 15'd1)))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!render_en_i && !addr_we_i && !data_acc_i) |=> $stable(vaddr_o)); // R10

  AST_CTRL_NO_V: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !render_en_i && !addr_we_i && !data_acc_i) |=> $stable(vaddr_o)); // R2
endmodule

bind scroll_addr_unit scroll_addr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .render_en_i (render_en_i),
  .wdata_i     (wdata_i),
  .ctrl_we_i   (ctrl_we_i),
  .scroll_we_i (scroll_we_i),
  .addr_we_i   (addr_we_i),
  .data_acc_i  (data_acc_i),
  .status_rd_i (status_rd_i),
  .vaddr_o     (vaddr_o),
  .fine_x_o    (fine_x_o),
  .toggle_i    (wr_toggle),
  .step_wide_i (step_wide)
);

// File: tb/tb_scroll_addr_unit.sv
module tb_scroll_addr_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  dot_i = '0;
  logic [8:0]  line_i = '0;
  logic        render_en_i = 1'b0;
  logic        prerender_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        ctrl_we_i = 1'b0, scroll_we_i = 1'b0, addr_we_i = 1'b0;
  logic        data_acc_i = 1'b0, status_rd_i = 1'b0;
  logic [14:0] vaddr_o;
  logic [2:0]  fine_x_o;

  always #2 clk_i = ~clk_i;

  scroll_addr_unit dut (.*);

  typedef struct {
    int    v;
    int    fx;
    string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0;
  int m_v = 0, m_t = 0, m_fx = 0, m_tog = 0, m_step = 1;
  bit done = 1'b0;

  function automatic int mdl_x(int v);
    if ((v & 31) == 31) return (v & ~31) ^ 'h400;
    return v + 1;
  endfunction

  function automatic int mdl_y(int v);
    int r, cy;
    if ((v & 'h7000) != 'h7000) return v + 'h1000;
    r  = v & ~'h7000;
    cy = (r >> 5) & 31;
    if (cy == 29) return (r & ~'h3E0) ^ 'h800;
    if (cy == 31) return r & ~'h3E0;
    return r + 'h20;
  endfunction

  task automatic close_cycle(input string tag);
    exp_t e;
    @(posedge clk_i);
    #1;
    ctrl_we_i = 0; scroll_we_i = 0; addr_we_i = 0;
    data_acc_i = 0; status_rd_i = 0; dot_i = '0; prerender_i = 0;
    e.v = m_v & 'h7FFF; e.fx = m_fx; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_ctrl(input int d, input string tag);
    @(negedge clk_i); wdata_i = 8'(d); ctrl_we_i = 1;
    m_t = (m_t & ~'hC00) | ((d & 3) << 10);
    m_step = (d & 4) ? 32 : 1;
    close_cycle(tag);
  endtask

  task automatic do_scroll(input int d, input string tag);
    @(negedge clk_i); wdata_i = 8'(d); scroll_we_i = 1;
    if (m_tog == 0) begin
      m_t = (m_t & ~'h1F) | ((d >> 3) & 31);
      m_fx = d & 7;
    end else begin
      m_t = (m_t & ~'h73E0) | ((d & 7) << 12) | (((d >> 3) & 31) << 5);
    end
    m_tog ^= 1;
    close_cycle(tag);
  endtask

  task automatic do_addr(input int d, input string tag);
    @(negedge clk_i); wdata_i = 8'(d); addr_we_i = 1;
    if (m_tog == 0) m_t = (m_t & 'hFF) | ((d & 'h3F) << 8);
    else begin
      m_t = (m_t & 'h7F00) | (d & 'hFF);
      m_v = m_t;
    end
    m_tog ^= 1;
    close_cycle(tag);
  endtask

  task automatic do_status(input string tag);
    @(negedge clk_i); status_rd_i = 1;
    m_tog = 0;
    close_cycle(tag);
  endtask

  task automatic do_data(input string tag);
    @(negedge clk_i); data_acc_i = 1;
    m_v = (m_v + m_step) & 'h7FFF;
    close_cycle(tag);
  endtask

  task automatic do_dot(input int ln, input int dt, input bit pre, input bit with_data,
                        input string tag);
    bit act;
    @(negedge clk_i);
    line_i = 9'(ln); dot_i = 9'(dt); prerender_i = pre; data_acc_i = with_data;
    act = render_en_i && (ln < 240 || pre);
    if (with_data) m_v = (m_v + m_step) & 'h7FFF;
    else if (act) begin
      if (dt == 256) m_v = mdl_y(m_v);
      else if (dt % 8 == 0 && ((dt >= 8 && dt < 256) || dt == 328 || dt == 336))
        m_v = mdl_x(m_v);
      if (dt == 257) m_v = (m_v & 'h7BE0) | (m_t & 'h041F);
      if (pre && dt >= 280 && dt <= 304) m_v = (m_v & 'h041F) | (m_t & 'h7BE0);
    end
    close_cycle(tag);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(vaddr_o) != e.v || int'(fine_x_o) != e.fx) begin
        errors++;
        $display("FAIL %s: vaddr=%h fx=%0d expected vaddr=%h fx=%0d",
                 e.tag, vaddr_o, fine_x_o, e.v[14:0], e.fx);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1;
    close_cycle("R1 reset state");

    // R3 scroll fields, R2 control field, observed through copies
    do_status("R5 status idle");
    do_scroll('h7D, "R3 first scroll write");
    do_scroll('h5E, "R3 second scroll write");
    do_ctrl('h02, "R2 control write");
    render_en_i = 1;
    do_dot(261, 257, 1, 0, "R9 horizontal copy");
    do_dot(261, 280, 1, 0, "R9 vertical copy");
    do_dot(261, 304, 1, 0, "R9 vertical copy end");

    // R4 / R5 phase and load
    render_en_i = 0;
    do_addr('h3F, "R4 first address write");
    do_status("R5 status read resets phase");
    do_addr('h21, "R4 first address write again");
    do_addr('h08, "R4 second address write loads");
    do_data("R6 data step 1");
    do_ctrl('h04, "R2 step 32 select");
    do_data("R6 data step 32");

    // build v = 0x7FFF
    do_addr('h3F, "R4 hi");
    do_addr('hFF, "R4 lo");
    do_scroll('hF8, "R3 first");
    do_scroll('hFF, "R3 second");
    render_en_i = 1;
    do_dot(261, 257, 1, 0, "R9 horizontal copy");
    do_dot(261, 290, 1, 0, "R9 vertical copy mid");
    render_en_i = 0;
    do_data("R6 wrap to 15 bits");

    // R7 / R8 on visible line
    do_addr('h3F, "R4 hi");
    do_addr('hFF, "R4 lo");
    do_scroll('hF8, "R3 first");
    do_scroll('hFF, "R3 second");
    render_en_i = 1;
    do_dot(261, 280, 1, 0, "R9 vertical copy");
    do_dot(10, 8, 0, 0, "R7 column wrap flips bit 10");
    do_dot(10, 16, 0, 0, "R7 column add one");
    do_dot(10, 264, 0, 0, "R7 dot 264 no step");
    do_dot(10, 320, 0, 0, "R7 dot 320 no step");
    do_dot(10, 328, 0, 0, "R7 prefetch dot 328");
    do_dot(10, 336, 0, 0, "R7 prefetch dot 336");
    do_dot(10, 256, 0, 0, "R8 row 31 wrap no flip");
    do_dot(10, 256, 0, 0, "R8 pixel row add one");
    do_dot(10, 280, 0, 0, "R9 no vertical copy off pre-render");

    // row 29 with pixel row 7
    do_scroll('h00, "R3 first");
    do_scroll('hEF, "R3 second row 29");
    do_dot(261, 300, 1, 0, "R9 vertical copy row 29");
    do_dot(20, 256, 0, 0, "R8 row 29 wraps and flips bit 11");
    do_scroll('h00, "R3 first");
    do_scroll('h57, "R3 second row 10");
    do_dot(261, 280, 1, 0, "R9 vertical copy row 10");
    do_dot(20, 256, 0, 0, "R8 row plain add");

    // R10 gating
    do_dot(245, 8, 0, 0, "R10 blanking line no step");
    do_dot(245, 257, 0, 0, "R10 blanking line no copy");
    render_en_i = 0;
    do_dot(10, 8, 0, 0, "R10 rendering off no step");
    do_dot(261, 280, 1, 0, "R10 rendering off no copy");
    render_en_i = 1;

    // R11 priority
    do_dot(10, 24, 0, 1, "R11 data access beats column step");
    render_en_i = 0;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule